// File: doc/BRIEF.md
# Lane-Partitioned Vector Add/Subtract Unit

This unit adds or subtracts two 64-bit operands that are read as packed vectors of small integers. Each operation picks its lane width (eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes), whether lanes hold two's-complement or unsigned numbers, and whether a result that does not fit is clamped to the nearest representable value or simply wraps. No carry ever crosses from one lane into the next.

An operation is issued by raising the strobe together with the operands and mode bits. Its result appears one clock later. A guard input can cancel an issued operation. A cancelled operation raises no output valid flag and leaves the result register unchanged. The unit holds no other state, so back-to-back operations can be issued on every cycle.

Top module: `simd_vector_adder`

## Requirements
- R1: While reset is asserted and after it is released, `valid_out` is 0 and `result` is all zeros until the first accepted operation.
- R2: An operation issued with `valid_in`=1 and `guard_in`=1 shows its result on `result` and raises `valid_out` at the next rising clock edge. This is one cycle of latency.
- R3: When `valid_in` or `guard_in` is 0 at an edge, `valid_out` is 0 after that edge and `result` keeps its previous value.
- R4: Lane width code `lane_size`: 2'b00 selects 8-bit lanes, 2'b01 selects 16-bit lanes, 2'b10 selects 32-bit lanes, and 2'b11 behaves exactly like 2'b10. Lane k occupies bits [k*W+W-1 : k*W].
- R5: With `saturate`=0, each lane of an add is (a+b) modulo 2^W, and no carry enters a neighbouring lane.
- R6: With `subtract`=1, each lane computes a + ~b + 1, that is a-b modulo 2^W when wrapping.
- R7: With `saturate`=1 and `is_signed`=0, a lane sum larger than 2^W-1 becomes all ones.
- R8: With `saturate`=1 and `is_signed`=0, a lane difference below zero becomes 0.
- R9: With `saturate`=1 and `is_signed`=1, a lane result above 2^(W-1)-1 becomes that value, and a lane result below -2^(W-1) becomes -2^(W-1).
- R10: With `saturate`=0, `is_signed` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operation issue strobe |
| guard_in | input | 1 | Operation predicate; 0 cancels the write |
| lane_size | input | 2 | Lane width code (00 byte, 01 half, 10/11 word) |
| is_signed | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| saturate | input | 1 | 1 = clamp on overflow, 0 = wrap |
| subtract | input | 1 | 1 = a minus b, 0 = a plus b |
| op_a | input | 64 | First operand vector |
| op_b | input | 64 | Second operand vector |
| result | output | 64 | Registered lane-wise result |
| valid_out | output | 1 | Result written on the previous edge |

## Verification
Directed vectors place all-ones and sign-boundary values in every lane. This separates clean lane isolation from a carry that leaks into the next lane, and it shows which clamp limit (zero, all ones, most positive or most negative) each mode reaches. The same operand pair is repeated with each lane width code, code 11 included, so that one pattern gives a different answer for each width. Random vectors cover every mix of width, signedness, clamping and direction. Some of them drop the guard or the strobe, which shows that a cancelled operation leaves the held result untouched. Pairs that differ only in the signedness bit under wrapping show that the bit has no effect there.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
   typedef enum logic [1:0] {
      LSZ_BYTE = 2'b00,
      LSZ_HALF = 2'b01,
      LSZ_WORD = 2'b10,
      LSZ_WALT = 2'b11
   } lane_size_e;

   localparam int unsigned MIN_LANE_W = 8;
   localparam int unsigned NUM_SIZES  = 3;

   function automatic int unsigned size_index(input logic [1:0] code);
      case (code)
         LSZ_BYTE: size_index = 0;
         LSZ_HALF: size_index = 1;
         default:  size_index = 2;
      endcase
   endfunction
endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit #(
   parameter int unsigned LANE_W = 8
) (
   input  logic [LANE_W-1:0] a_i,
   input  logic [LANE_W-1:0] b_i,
   input  logic              sub_i,
   input  logic              sgn_i,
   input  logic              sat_i,
   output logic [LANE_W-1:0] res_o
);
   localparam logic [LANE_W-1:0] ALL_ONES = {LANE_W{1'b1}};
   localparam logic [LANE_W-1:0] S_MAX    = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] S_MIN    = {1'b1, {(LANE_W-1){1'b0}}};

   if (LANE_W < 2) begin : g_bad_w
      $error("simd_lane_unit: LANE_W must be at least 2");
   end

   logic [LANE_W-1:0] b_eff;
   logic [LANE_W:0]   sum_ext;
   logic [LANE_W-1:0] raw;
   logic              carry_out;
   logic              u_ovf, s_ovf;
   logic [LANE_W-1:0] clamp_val;

   always_comb begin
      b_eff     = sub_i ? ~b_i : b_i;
      sum_ext   = {1'b0, a_i} + {1'b0, b_eff} + {{LANE_W{1'b0}}, sub_i};
      raw       = sum_ext[LANE_W-1:0];
      carry_out = sum_ext[LANE_W];
      // unsigned: add overflows on carry, subtract underflows on missing carry
      u_ovf     = sub_i ? ~carry_out : carry_out;
      s_ovf     = (a_i[LANE_W-1] == b_eff[LANE_W-1]) && (raw[LANE_W-1] != a_i[LANE_W-1]);
      if (sgn_i)
         clamp_val = a_i[LANE_W-1] ? S_MIN : S_MAX;
      else
         clamp_val = sub_i ? '0 : ALL_ONES;
      if (sat_i && (sgn_i ? s_ovf : u_ovf))
         res_o = clamp_val;
      else
         res_o = raw;
   end

   always_comb begin
      if (sat_i && !sgn_i && !sub_i)
         assert_usat_add_floor_R7: assert (res_o >= a_i);
      if (sat_i && !sgn_i && sub_i)
         assert_usat_sub_ceiling_R8: assert (res_o <= a_i);
      if (sat_i && sgn_i && !a_i[LANE_W-1] && !b_eff[LANE_W-1])
         assert_ssat_pos_sign_R9: assert (!res_o[LANE_W-1]);
      if (sat_i && sgn_i && a_i[LANE_W-1] && b_eff[LANE_W-1])
         assert_ssat_neg_sign_R9: assert (res_o[LANE_W-1]);
   end
endmodule

// File: rtl/simd_width_bank.sv
module simd_width_bank #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned LANE_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   input  logic              sgn_i,
   input  logic              sat_i,
   output logic [DATA_W-1:0] res_o
);
   localparam int unsigned LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_split
      $error("simd_width_bank: DATA_W must be a multiple of LANE_W");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      simd_lane_unit #(.LANE_W(LANE_W)) u_lane (
         .a_i   (a_i[k*LANE_W +: LANE_W]),
         .b_i   (b_i[k*LANE_W +: LANE_W]),
         .sub_i (sub_i),
         .sgn_i (sgn_i),
         .sat_i (sat_i),
         .res_o (res_o[k*LANE_W +: LANE_W])
      );
   end
endmodule

// File: rtl/simd_vector_adder.sv
module simd_vector_adder #(
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic              guard_in,
   input  logic [1:0]        lane_size,
   input  logic              is_signed,
   input  logic              saturate,
   input  logic              subtract,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] result,
   output logic              valid_out
);
   import simd_add_pkg::*;

   localparam int unsigned MAX_LANE_W = MIN_LANE_W << (NUM_SIZES - 1);

   if (DATA_W % MAX_LANE_W != 0) begin : g_bad_data_w
      $error("simd_vector_adder: DATA_W must be a multiple of the widest lane");
   end

   logic [DATA_W-1:0] bank_res [NUM_SIZES];
   logic [DATA_W-1:0] sel_res;
   logic              accept;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_bank
      simd_width_bank #(
         .DATA_W (DATA_W),
         .LANE_W (MIN_LANE_W << s)
      ) u_bank (
         .a_i   (op_a),
         .b_i   (op_b),
         .sub_i (subtract),
         .sgn_i (is_signed),
         .sat_i (saturate),
         .res_o (bank_res[s])
      );
   end

   always_comb begin
      sel_res = bank_res[size_index(lane_size)];
      accept  = valid_in && guard_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result    <= '0;
         valid_out <= 1'b0;
      end else begin
         valid_out <= accept;
         if (accept)
            result <= sel_res;
      end
   end

   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && guard_in) |=> valid_out);
   assert_guard_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_in && guard_in) |=> !valid_out);
   assert_hold_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_in && guard_in) |=> $stable(result));
endmodule

// File: tb/simd_vector_adder_bench.sv
module simd_vector_adder_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam int  DATA_W     = 64;
   localparam int  N_RANDOM   = 400;
   localparam int  WATCHDOG   = 20000;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              valid_in, guard_in, is_signed, saturate, subtract;
   logic [1:0]        lane_size;
   logic [DATA_W-1:0] op_a, op_b;
   logic [DATA_W-1:0] result;
   logic              valid_out;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;
   logic [DATA_W-1:0] held;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_vector_adder #(.DATA_W(DATA_W)) u_simd_vector_adder (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .guard_in(guard_in),
      .lane_size(lane_size), .is_signed(is_signed), .saturate(saturate),
      .subtract(subtract), .op_a(op_a), .op_b(op_b),
      .result(result), .valid_out(valid_out)
   );

   function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                         input logic [1:0] sz, input bit sgn,
                                         input bit sat, input bit sub);
      int w;
      longint va, vb, r, lo, hi, mask;
      logic [63:0] out;
      w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
      mask = (longint'(1) << w) - 1;
      out = '0;
      for (int i = 0; i < 64 / w; i++) begin
         va = longint'((a >> (i * w))) & mask;
         vb = longint'((b >> (i * w))) & mask;
         if (sgn) begin
            if (va >= (longint'(1) << (w - 1))) va = va - (longint'(1) << w);
            if (vb >= (longint'(1) << (w - 1))) vb = vb - (longint'(1) << w);
            lo = -(longint'(1) << (w - 1));
            hi = (longint'(1) << (w - 1)) - 1;
         end else begin
            lo = 0;
            hi = mask;
         end
         r = sub ? va - vb : va + vb;
         if (sat) begin
            if (r > hi) r = hi;
            if (r < lo) r = lo;
         end
         out = out | (64'(r & mask) << (i * w));
      end
      return out;
   endfunction

   task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                        input bit sgn, input bit sat, input bit sub,
                        input bit vld, input bit grd, input string tag);
      logic [63:0] exp_res;
      bit exp_v;
      @(negedge clk);
      op_a = a; op_b = b; lane_size = sz; is_signed = sgn; saturate = sat;
      subtract = sub; valid_in = vld; guard_in = grd;
      exp_v = vld && grd;
      exp_res = exp_v ? model(a, b, sz, sgn, sat, sub) : held;
      @(negedge clk);
      vectors++;
      if (valid_out !== exp_v || result !== exp_res) begin
         miscompares++;
         $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
                  tag, result, valid_out, exp_res, exp_v);
      end
      held = exp_res;
      valid_in = 1'b0;
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: result=%h valid=%b expected completion", result, valid_out);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : stim
      int unsigned seed_val;
      logic [63:0] ra, rb;
      logic [1:0] rsz;
      bit rsg, rst, rsb, rv, rg;
      string tag;
      seed_val = $urandom(32'd7301);
      rst_n = 1'b0; valid_in = 0; guard_in = 0; lane_size = 0; is_signed = 0;
      saturate = 0; subtract = 0; op_a = '0; op_b = '0; held = '0;
      repeat (3) @(negedge clk);
      vectors++;
      if (result !== '0 || valid_out !== 1'b0) begin
         miscompares++;
         $display("FAIL R1: result=%h valid=%b expected result=0 valid=0", result, valid_out);
      end
      rst_n = 1'b1;
      @(negedge clk);
      vectors++;
      if (result !== '0 || valid_out !== 1'b0) begin
         miscompares++;
         $display("FAIL R1: result=%h valid=%b expected result=0 valid=0 after release", result, valid_out);
      end

      // R5: all-ones plus one must not leak carries between lanes
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 0, 0, 0, 1, 1, "R5 byte");
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'b01, 0, 0, 0, 1, 1, "R5 half");
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'b10, 0, 0, 0, 1, 1, "R5 word");
      // R4: same pair, every code; code 11 equals word
      for (int c = 0; c < 4; c++)
         apply(64'h80FF_7F01_00FF_FF80, 64'h8001_0101_FF01_8080, 2'(c), 0, 0, 0, 1, 1, "R4");
      // R6: wrap subtraction borrow stays in lane
      apply(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 2'b00, 0, 0, 1, 1, 1, "R6");
      // R7 / R8 unsigned clamps
      apply(64'hF0F0_F0F0_F0F0_F0F0, 64'h2020_2020_2020_2020, 2'b00, 0, 1, 0, 1, 1, "R7");
      apply(64'hFFF0_0010_FFF0_0010, 64'h0020_0020_0020_0020, 2'b01, 0, 1, 0, 1, 1, "R7 half");
      apply(64'h0010_0010_0000_0005, 64'h0020_0001_0000_0009, 2'b01, 0, 1, 1, 1, 1, "R8");
      // R9 signed clamps at both ends
      apply(64'h7F80_7F80_7F80_7F80, 64'h0180_0180_0180_0180, 2'b00, 1, 1, 0, 1, 1, "R9 add");
      apply(64'h7FFF_FFFF_8000_0000, 64'hFFFF_FFFF_0000_0001, 2'b10, 1, 1, 1, 1, 1, "R9 sub");
      // R10: signedness ignored when wrapping
      apply(64'h7F80_7F80_1234_ABCD, 64'h0180_FF80_F00D_5555, 2'b00, 1, 0, 0, 1, 1, "R10 signed");
      apply(64'h7F80_7F80_1234_ABCD, 64'h0180_FF80_F00D_5555, 2'b00, 0, 0, 0, 1, 1, "R10 unsigned");
      // R3: guard low and strobe low keep held result
      apply(64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 2'b00, 0, 0, 0, 1, 0, "R3 guard");
      apply(64'h3333_3333_3333_3333, 64'h2222_2222_2222_2222, 2'b00, 0, 0, 0, 0, 1, "R3 strobe");
      // R2: accepted op after cancel appears after one edge
      apply(64'h0000_0001_0000_0002, 64'h0000_0003_0000_0004, 2'b10, 0, 0, 0, 1, 1, "R2");

      for (int n = 0; n < N_RANDOM; n++) begin
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         rsz = 2'($urandom);
         rsg = 1'($urandom); rst = 1'($urandom); rsb = 1'($urandom);
         rv = ($urandom % 10) != 0;
         rg = ($urandom % 10) != 0;
         if (!(rv && rg)) tag = "R3 random";
         else if (rst) tag = rsg ? "R9 random" : (rsb ? "R8 random" : "R7 random");
         else tag = rsb ? "R6 random" : "R5 random";
         apply(ra, rb, rsz, rsg, rst, rsb, rv, rg, tag);
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule